// File: doc/BRIEF.md
# Vector Alignment Permute Unit

This block serves the two halves of the unaligned vector access pattern. In mask mode it receives a 32-bit instruction word, decodes it as one of two shift-mask encodings, and offers the base and index register numbers on its select outputs. The surrounding logic returns the two 64-bit general-purpose values. The unit adds them, keeps the low four bits of the sum as the byte offset, and emits a 16-byte permute control vector together with a 7-bit destination vector register number. A side input chooses between the shift-right mask, which is the default, and the shift-left mask. No memory is read.

In permute mode the unit takes two 128-bit source vectors and a 128-bit control vector and builds each output byte by picking one byte out of the 32 source bytes. Software loads two aligned blocks, derives a shift-right mask from the address, and then permutes with the higher block as the first source. The result is the unaligned vector. Both modes return their result one cycle after the input pulse, with a one-cycle strobe.

Top module: `vec_align_perm`

## Requirements
- R1: After synchronous reset, out_valid and illegal are 0, and out_vec and dest_idx are all zeros.
- R2: An accepted input pulse produces exactly one output strobe on the following cycle. That strobe is out_valid for a recognised word or any permute, and illegal otherwise. No strobe appears without an input pulse.
- R3: The byte offset sh is the low 4 bits of the 64-bit wrapping sum of the base value and the index value. When the base register field is 0, the base is the literal zero and base_val is ignored.
- R4: Shift-right mask (left_mask=0): byte i of out_vec equals 16 - sh + i for i = 0..15. Byte 0 is out_vec[127:120]. sh=0 gives 16..31 and sh=3 gives 13..28.
- R5: Shift-left mask (left_mask=1): byte i of out_vec equals sh + i.
- R6: The short form is recognised when insn[31:26]=31 and insn[10:1]=38. Its destination is {2'b00, insn[25:21]}, the base field is insn[20:16] and the index field is insn[15:11]. The base and index fields appear combinationally on base_sel and index_sel.
- R7: The wide form is recognised when (insn & 32'hFC0007F3) == 32'h10000043. Its destination is {insn[3:2], insn[25:21]}, which reaches registers 0..127. Its base and index fields sit in the same positions as in the short form.
- R8: In mask mode, a word that matches neither form raises illegal for one cycle. out_valid stays low, and out_vec and dest_idx keep their previous values.
- R9: In permute mode, output byte i is selected by the low five bits of control byte i. Bit 4 picks src_b when set and src_a when clear, and bits 3..0 pick the byte within that source, with byte 0 being the most significant. Control bits 7..5 have no effect, and dest_idx is left unchanged.
- R10: Permuting with the next aligned block as src_a, the current block as src_b, and the shift-right mask for offset sh yields the 32-byte pair {src_a, src_b} shifted right by sh bytes (its low 16 bytes).

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle operation request |
| perm_mode | input | 1 | 1 = permute, 0 = mask generation |
| left_mask | input | 1 | In mask mode, 1 selects the shift-left mask |
| insn | input | 32 | Instruction word for mask mode |
| base_val | input | 64 | Value of the register named on base_sel |
| index_val | input | 64 | Value of the register named on index_sel |
| src_a | input | 128 | First permute source (selector bit 4 clear) |
| src_b | input | 128 | Second permute source (selector bit 4 set) |
| ctrl | input | 128 | Permute control, one selector per byte |
| base_sel | output | 5 | Decoded base register field |
| index_sel | output | 5 | Decoded index register field |
| out_valid | output | 1 | Result strobe |
| illegal | output | 1 | Unrecognised instruction word strobe |
| out_vec | output | 128 | Mask or permuted vector, byte 0 in the top bits |
| dest_idx | output | 7 | Destination vector register number |

## Verification
A wrong offset or a wrong mask base shows up in out_vec on the cycle right after the request. The selectors are then off by a constant, so every byte is wrong in the same way. A decode slip shows up instead in dest_idx, in a missing out_valid, or in a stray illegal strobe on that same cycle. The alignment idiom sweep over all sixteen offsets turns any selector or byte-order fault into a mismatch against the byte-shifted reference on the first permute of the affected offset. A bad hold path shows up only on the strobe after an illegal word or a permute, where dest_idx or out_vec moves when it should stay put.

// File: rtl/vap_pkg.sv
package vap_pkg;
  localparam logic [31:0] SHORT_MASK  = 32'hFC0007FE;
  localparam logic [31:0] SHORT_MATCH = 32'h7C00004C;
  localparam logic [31:0] WIDE_MASK   = 32'hFC0007F3;
  localparam logic [31:0] WIDE_MATCH  = 32'h10000043;

  typedef struct packed {
    logic       hit_short;
    logic       hit_wide;
    logic [4:0] base_fld;
    logic [4:0] index_fld;
    logic [6:0] dest;
  } dec_t;
endpackage

// File: rtl/vap_decode.sv
module vap_decode
  import vap_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb begin
    dec.hit_short = (insn & SHORT_MASK) == SHORT_MATCH;
    dec.hit_wide  = (insn & WIDE_MASK) == WIDE_MATCH;
    dec.base_fld  = insn[20:16];
    dec.index_fld = insn[15:11];
    if (dec.hit_wide) dec.dest = {insn[3:2], insn[25:21]};
    else              dec.dest = {2'b00, insn[25:21]};
  end
endmodule

// File: rtl/vap_mask_gen.sv
module vap_mask_gen #(
  parameter int NBYTES = 16,
  localparam int SHW = $clog2(NBYTES),
  localparam int VW  = 8 * NBYTES
) (
  input  logic [SHW-1:0] sh,
  input  logic           left,
  output logic [VW-1:0]  mask
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] val;
    always_comb begin
      if (left) val = 8'(g) + 8'(sh);
      else      val = 8'(NBYTES) - 8'(sh) + 8'(g);
    end
    assign mask[8*(NBYTES-1-g) +: 8] = val;
  end
endmodule

// File: rtl/vap_permute.sv
module vap_permute #(
  parameter int NBYTES = 16,
  localparam int SHW = $clog2(NBYTES),
  localparam int VW  = 8 * NBYTES
) (
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] ctrl,
  output logic [VW-1:0] res
);
  logic [7:0] a_by [NBYTES];
  logic [7:0] b_by [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign a_by[g] = src_a[8*(NBYTES-1-g) +: 8];
    assign b_by[g] = src_b[8*(NBYTES-1-g) +: 8];
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_pick
    logic [7:0]     sel;
    logic [SHW-1:0] idx;
    logic           from_b;
    assign sel    = ctrl[8*(NBYTES-1-g) +: 8];
    assign idx    = sel[SHW-1:0];
    assign from_b = sel[SHW];
    assign res[8*(NBYTES-1-g) +: 8] = from_b ? b_by[idx] : a_by[idx];
  end
endmodule

// File: rtl/vec_align_perm.sv
module vec_align_perm
  import vap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NBYTES = 16,
  localparam int SHW = $clog2(NBYTES),
  localparam int VW  = 8 * NBYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            perm_mode,
  input  logic            left_mask,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [VW-1:0]   src_a,
  input  logic [VW-1:0]   src_b,
  input  logic [VW-1:0]   ctrl,
  output logic [4:0]      base_sel,
  output logic [4:0]      index_sel,
  output logic            out_valid,
  output logic            illegal,
  output logic [VW-1:0]   out_vec,
  output logic [6:0]      dest_idx
);
  dec_t            dec;
  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] ea;
  logic [SHW-1:0]  sh;
  logic [VW-1:0]   mask_res;
  logic [VW-1:0]   perm_res;
  logic            recog;

  vap_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  assign base_sel  = dec.base_fld;
  assign index_sel = dec.index_fld;
  assign recog     = dec.hit_short | dec.hit_wide;

  always_comb begin
    base_eff = (dec.base_fld == 5'd0) ? '0 : base_val;
    ea       = base_eff + index_val;
    sh       = ea[SHW-1:0];
  end

  vap_mask_gen #(.NBYTES(NBYTES)) u_mask (
    .sh   (sh),
    .left (left_mask),
    .mask (mask_res)
  );

  vap_permute #(.NBYTES(NBYTES)) u_perm (
    .src_a (src_a),
    .src_b (src_b),
    .ctrl  (ctrl),
    .res   (perm_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      out_vec   <= '0;
      dest_idx  <= '0;
    end else begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      if (in_valid) begin
        if (perm_mode) begin
          out_vec   <= perm_res;
          out_valid <= 1'b1;
        end else if (recog) begin
          out_vec   <= mask_res;
          dest_idx  <= dec.dest;
          out_valid <= 1'b1;
        end else begin
          illegal <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vap_checker.sv
module vap_checker
  import vap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NBYTES = 16,
  localparam int VW = 8 * NBYTES
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            perm_mode,
  input logic            left_mask,
  input logic [31:0]     insn,
  input logic            out_valid,
  input logic            illegal,
  input logic [VW-1:0]   out_vec,
  input logic [6:0]      dest_idx
);
  logic short_hit, wide_hit, mask_req;
  assign short_hit = (insn & SHORT_MASK) == SHORT_MATCH;
  assign wide_hit  = (insn & WIDE_MASK) == WIDE_MATCH;
  assign mask_req  = in_valid && !perm_mode && (short_hit || wide_hit);

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid ^ illegal));

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !illegal));

  a_r4_right_base: assert property (@(posedge clk) disable iff (rst)
    (mask_req && !left_mask) |=>
      (out_vec[VW-1 -: 8] >= 8'd1 && out_vec[VW-1 -: 8] <= 8'(NBYTES)));

  a_r5_left_base: assert property (@(posedge clk) disable iff (rst)
    (mask_req && left_mask) |=> (out_vec[VW-1 -: 8] < 8'(NBYTES)));

  a_r6_short_dest: assert property (@(posedge clk) disable iff (rst)
    (mask_req && short_hit) |=> (dest_idx == {2'b00, $past(insn[25:21])}));

  a_r7_wide_dest: assert property (@(posedge clk) disable iff (rst)
    (mask_req && wide_hit) |=> (dest_idx == {$past(insn[3:2]), $past(insn[25:21])}));

  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(out_vec) && $stable(dest_idx)));

  a_r9_perm_keeps_dest: assert property (@(posedge clk) disable iff (rst)
    (in_valid && perm_mode) |=> $stable(dest_idx));
endmodule

bind vec_align_perm vap_checker #(.XLEN(XLEN), .NBYTES(NBYTES)) u_vap_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .perm_mode (perm_mode),
  .left_mask (left_mask),
  .insn      (insn),
  .out_valid (out_valid),
  .illegal   (illegal),
  .out_vec   (out_vec),
  .dest_idx  (dest_idx)
);

// File: tb/vec_align_perm_bench.sv
module vec_align_perm_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, perm_mode, left_mask;
  logic [31:0]  insn;
  logic [63:0]  base_val, index_val;
  logic [127:0] src_a, src_b, ctrl;
  logic [4:0]   base_sel, index_sel;
  logic         out_valid, illegal;
  logic [127:0] out_vec;
  logic [6:0]   dest_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  vec_align_perm u_vec_align_perm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .perm_mode(perm_mode),
    .left_mask(left_mask), .insn(insn), .base_val(base_val),
    .index_val(index_val), .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
    .base_sel(base_sel), .index_sel(index_sel), .out_valid(out_valid),
    .illegal(illegal), .out_vec(out_vec), .dest_idx(dest_idx)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_short(input logic [4:0] rd, input logic [4:0] ra, input logic [4:0] rb);
    return {6'd31, rd, ra, rb, 10'd38, 1'b0};
  endfunction

  function automatic logic [31:0] enc_wide(input logic [6:0] vd, input logic [4:0] ra, input logic [4:0] rb);
    return {6'd4, vd[4:0], ra, rb, 7'd4, vd[6:5], 2'b11};
  endfunction

  function automatic logic [127:0] ref_mask(input logic [3:0] sh, input bit left);
    logic [127:0] m;
    for (int i = 0; i < 16; i++)
      m[127-8*i -: 8] = left ? 8'(sh + i) : 8'(16 - sh + i);
    return m;
  endfunction

  // inputs set after a falling edge; pulse in_valid for one cycle; outputs sampled at the next falling edge
  task automatic fire();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mask_op(input logic [31:0] w, input logic [63:0] b, input logic [63:0] x, input bit left);
    perm_mode = 1'b0; left_mask = left; insn = w; base_val = b; index_val = x;
    fire();
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; perm_mode = 1'b0; left_mask = 1'b0;
    insn = '0; base_val = '0; index_val = '0; src_a = '0; src_b = '0; ctrl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 out_valid", 128'(out_valid), 128'd0);
    chk("R1 illegal", 128'(illegal), 128'd0);
    chk("R1 out_vec", out_vec, '0);
    chk("R1 dest_idx", 128'(dest_idx), 128'd0);
  endtask

  task automatic t_short_right();
    // base field 7 nonzero: base 0x100 + index 0x3 -> sh=3
    mask_op(enc_short(5'd9, 5'd7, 5'd12), 64'h100, 64'h3, 1'b0);
    chk("R6 base_sel", 128'(base_sel), 128'd7);
    chk("R6 index_sel", 128'(index_sel), 128'd12);
    chk("R2 out_valid", 128'(out_valid), 128'd1);
    chk("R4 mask sh=3", out_vec, ref_mask(4'd3, 1'b0));
    chk("R6 dest", 128'(dest_idx), 128'd9);
    @(negedge clk);
    chk("R2 single strobe", 128'(out_valid), 128'd0);
    mask_op(enc_short(5'd1, 5'd2, 5'd3), 64'h40, 64'h80, 1'b0);
    chk("R4 mask sh=0", out_vec, ref_mask(4'd0, 1'b0));
  endtask

  task automatic t_base_zero_and_wrap();
    // base field 0: base_val must be ignored
    mask_op(enc_short(5'd4, 5'd0, 5'd5), 64'h0000_0000_0000_000B, 64'h25, 1'b0);
    chk("R3 zero base", out_vec, ref_mask(4'd5, 1'b0));
    // wrapping sum: all-ones + 5 -> low nibble 4
    mask_op(enc_short(5'd4, 5'd6, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 1'b0);
    chk("R3 wrap", out_vec, ref_mask(4'd4, 1'b0));
  endtask

  task automatic t_left();
    mask_op(enc_short(5'd2, 5'd1, 5'd2), 64'h7, 64'h4, 1'b1);
    chk("R5 left sh=11", out_vec, ref_mask(4'd11, 1'b1));
    mask_op(enc_wide(7'd0, 5'd0, 5'd2), 64'h0, 64'hF, 1'b1);
    chk("R5 left sh=15", out_vec, ref_mask(4'd15, 1'b1));
  endtask

  task automatic t_wide();
    mask_op(enc_wide(7'd117, 5'd3, 5'd4), 64'h8, 64'h1, 1'b0);
    chk("R7 valid", 128'(out_valid), 128'd1);
    chk("R7 dest", 128'(dest_idx), 128'd117);
    chk("R7 mask sh=9", out_vec, ref_mask(4'd9, 1'b0));
  endtask

  task automatic t_illegal();
    logic [127:0] prev_vec;
    logic [6:0]   prev_dest;
    prev_vec = out_vec; prev_dest = dest_idx;
    mask_op(enc_short(5'd30, 5'd1, 5'd1) ^ 32'h0000_0002, 64'h1, 64'h1, 1'b0);
    chk("R8 illegal", 128'(illegal), 128'd1);
    chk("R8 no valid", 128'(out_valid), 128'd0);
    chk("R8 vec held", out_vec, prev_vec);
    chk("R8 dest held", 128'(dest_idx), 128'(prev_dest));
    // wide form with reserved bits cleared is also unrecognised
    mask_op(enc_wide(7'd5, 5'd1, 5'd1) & ~32'h3, 64'h1, 64'h1, 1'b0);
    chk("R8 wide reserved", 128'(illegal), 128'd1);
    @(negedge clk);
    chk("R2 no strobe idle", 128'({out_valid, illegal}), 128'd0);
  endtask

  task automatic t_perm();
    logic [127:0] a, b, c, e;
    logic [6:0]   d0;
    for (int i = 0; i < 16; i++) begin
      a[127-8*i -: 8] = 8'(8'hA0 + i);
      b[127-8*i -: 8] = 8'(8'hB0 + i);
    end
    // selector j with junk in bits 7..5; j runs backwards through both sources
    for (int i = 0; i < 16; i++) begin
      logic [4:0] j;
      j = 5'(31 - 2*i);
      c[127-8*i -: 8] = {3'b101, j};
      e[127-8*i -: 8] = j[4] ? 8'(8'hB0 + j[3:0]) : 8'(8'hA0 + j[3:0]);
    end
    d0 = dest_idx;
    perm_mode = 1'b1; src_a = a; src_b = b; ctrl = c;
    fire();
    chk("R9 permute", out_vec, e);
    chk("R9 valid", 128'(out_valid), 128'd1);
    chk("R9 dest kept", 128'(dest_idx), 128'(d0));
  endtask

  task automatic t_idiom();
    logic [127:0] lo, hi, m, refv;
    logic [255:0] pair;
    for (int i = 0; i < 16; i++) begin
      lo[127-8*i -: 8] = 8'(i * 7 + 3);
      hi[127-8*i -: 8] = 8'(8'h80 + i * 5);
    end
    pair = {hi, lo};
    for (int s = 0; s < 16; s++) begin
      mask_op(enc_short(5'd3, 5'd8, 5'd9), 64'h1000, 64'(s), 1'b0);
      m = out_vec;
      perm_mode = 1'b1; src_a = hi; src_b = lo; ctrl = m;
      fire();
      refv = 128'(pair >> (8 * s));
      chk($sformatf("R10 idiom sh=%0d", s), out_vec, refv);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_short_right();
    t_base_zero_and_wrap();
    t_left();
    t_wide();
    t_illegal();
    t_perm();
    t_idiom();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule